// File: doc/BRIEF.md
# Binary/Gray Selectable Up Counter

This block is a synchronous up counter, three bits wide by default, that holds one stored code and advances it on each enabled clock edge. A mode input, sampled at every edge, picks which successor function applies. With the mode low the code steps through plain binary order. With the mode high it steps through reflected Gray order, so each step changes exactly one bit.

Both orders act on the same register. The mode may change on any cycle. The next code is always computed from the value now stored, read in the order that is selected at that edge. It does not depend on how the counter reached that value. A synchronous reset returns the counter to all zeros. A low enable holds the stored code.

Top module: `mode_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 000 after that edge.
- R2: Reset takes priority: with `rst` high, `count` becomes 000 whatever the values of `cnt_en` and `gray_mode`.
- R3: With `rst` low and `cnt_en` low at an edge, `count` keeps its value whatever the value of `gray_mode`.
- R4: With `cnt_en` high and `gray_mode` at 0, `count` advances in binary order: 000, 001, 010, 011, 100, 101, 110, 111.
- R5: In binary mode the code 111 is followed by 000.
- R6: With `cnt_en` high and `gray_mode` at 1, `count` advances in Gray order: 000, 001, 011, 010, 110, 111, 101, 100.
- R7: In Gray mode the code 100 is followed by 000.
- R8: Every enabled step in Gray mode changes exactly one bit of `count`.
- R9: The successor is taken from the stored code in the mode sampled at that edge, whatever the path that led there. For example, 010 reached by binary counting goes to 110 on a Gray step, and 110 reached by Gray counting goes to 111 on a binary step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance enable; the value holds when low |
| gray_mode | input | 1 | Order select: 0 binary, 1 reflected Gray |
| count | output | W (3) | Stored counter code |

## Verification
The assertions check on every cycle the effect of reset, the hold when the enable is low, the +1 step with binary wrap, the single-bit change of each Gray step, and the Gray wrap from 100. Only the bench scenarios can show that the full eight-entry Gray order is followed and that switching mode continues correctly from every one of the eight codes, whichever order was used to reach it. These checks need the whole successor table, which the bench builds from the listed sequences.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic {
    MODE_BIN  = 1'b0,
    MODE_GRAY = 1'b1
  } mode_e;
endpackage

// File: rtl/mc_next_code.sv
module mc_next_code #(
  parameter int W = 3
) (
  input  logic [W-1:0] cur,
  input  logic         mode_bit,
  output logic [W-1:0] nxt,
  output logic [W-1:0] step_bin,
  output logic [W-1:0] step_gray
);
  import mc_pkg::*;

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic logic [W-1:0] bin_to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] incr(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  mode_e mode_sel;
  assign mode_sel = mode_e'(mode_bit);

  always_comb begin
    step_bin  = incr(cur);
    step_gray = bin_to_gray(incr(gray_to_bin(cur)));
    nxt       = (mode_sel == MODE_GRAY) ? step_gray : step_bin;
  end
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/mode_counter.sv
module mode_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         gray_mode,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] GRAY_LAST = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q;
  logic [W-1:0] code_d;
  logic [W-1:0] step_bin;
  logic [W-1:0] step_gray;
  logic         adv_evt;

  assign adv_evt = cnt_en && !rst;

  mc_next_code #(.W(W)) u_next (
    .cur       (code_q),
    .mode_bit  (gray_mode),
    .nxt       (code_d),
    .step_bin  (step_bin),
    .step_gray (step_gray)
  );

  mc_state_reg #(.W(W)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (cnt_en),
    .d    (code_d),
    .q    (code_q)
  );

  assign count = code_q;

  // R1 / R2: reset wins over enable and mode
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (count == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

  // R4 / R5: binary step is +1 modulo 2**W
  assert_bin_step_R4: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && !gray_mode) |=> (count == W'($past(count) + W'(1))));

  assert_gray_onebit_R8: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && gray_mode) |=> ($countones(count ^ $past(count)) == 1));

  assert_gray_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && gray_mode && count == GRAY_LAST) |=> (count == '0));
endmodule

// File: tb/mode_counter_bench.sv
module mode_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       gray_mode = 1'b0;
  logic [2:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0] gseq [8] = '{3'b000, 3'b001, 3'b011, 3'b010,
                           3'b110, 3'b111, 3'b101, 3'b100};

  always #10 clk = ~clk;

  mode_counter u_mode_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .gray_mode(gray_mode), .count(count)
  );

  function automatic logic [2:0] gray_after(input logic [2:0] c);
    for (int i = 0; i < 8; i++) if (gseq[i] == c) return gseq[(i + 1) % 8];
    return 3'bxxx;
  endfunction

  task automatic tick(input bit r, input bit e, input bit m);
    rst = r; cnt_en = e; gray_mode = m;
    @(posedge clk); #3;
  endtask

  task automatic chk(input string req, input logic [2:0] exp);
    checks++;
    if (count !== exp) begin
      failures++;
      $display("FAIL %s: count=%b expected=%b", req, count, exp);
    end
  endtask

  task automatic t_reset;
    tick(1, 0, 0); chk("R1", 3'b000);
    tick(0, 1, 0); tick(0, 1, 0);
    tick(1, 1, 1); chk("R2", 3'b000);
    tick(0, 1, 0); tick(1, 1, 0); chk("R2", 3'b000);
  endtask

  task automatic t_hold;
    tick(1, 0, 0);
    for (int k = 0; k < 5; k++) tick(0, 1, 0);
    tick(0, 0, 0); chk("R3", 3'b101);
    tick(0, 0, 1); chk("R3", 3'b101);
    tick(0, 0, 0); chk("R3", 3'b101);
  endtask

  task automatic t_binary;
    logic [2:0] e;
    tick(1, 0, 0);
    e = 3'b000;
    for (int k = 0; k < 8; k++) begin
      e = e + 3'd1;
      tick(0, 1, 0);
      chk((k == 7) ? "R5" : "R4", e);
    end
  endtask

  task automatic t_gray;
    logic [2:0] prev;
    tick(1, 0, 1);
    for (int k = 1; k <= 8; k++) begin
      prev = count;
      tick(0, 1, 1);
      chk((k == 8) ? "R7" : "R6", gseq[k % 8]);
      checks++;
      if ($countones(count ^ prev) != 1) begin
        failures++;
        $display("FAIL R8: count=%b previous=%b expected one-bit change", count, prev);
      end
    end
  endtask

  task automatic t_switch;
    for (int c = 0; c < 8; c++) begin
      tick(1, 0, 0);
      for (int k = 0; k < c; k++) tick(0, 1, 0);
      tick(0, 1, 1); chk("R9", gray_after(3'(c)));
      tick(1, 0, 1);
      for (int k = 0; k < c; k++) tick(0, 1, 1);
      tick(0, 1, 0); chk("R9", gseq[c] + 3'd1);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: count=%b expected=finish", count);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset();
    t_hold();
    t_binary();
    t_gray();
    t_switch();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule